// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen 32-bit general registers of a processor core. Some of them are duplicated per privilege mode. The live set is always visible on two combinational read ports and one synchronous write port. A 5-bit mode input, qualified by a strobe, selects the privilege mode. When the newly selected mode belongs to a different bank group than the current one, the block moves state between the live set and the banks on a single clock edge:

- the stack pointer (r13), the link register (r14) and the saved-status word are written out to the old group's bank and loaded from the new group's bank;
- when the fast-interrupt mode is on either side of the change, r8 to r12 are exchanged as well.

User and system mode form one unbanked group. That group has no saved-status word, so the status port reads zero there. Mode encodings: user 0x10, fast-interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B, system 0x1F. Any other value joins the unbanked group.

Top module: `banked_regfile`

## Requirements
- R1: Reset clears all sixteen live registers, every banked copy and every saved-status word, and sets the mode to system (0x1F).
- R2: A write with `reg_we` high stores `reg_wdata` into register `reg_waddr`, and the value is visible on both read ports from the next cycle.
- R3: A change between user (0x10) and system (0x1F) moves no register.
- R4: Entering a banked mode loads r13/r14 from that mode's bank. Returning to the earlier group restores the earlier r13/r14 values.
- R5: Fast-interrupt, interrupt, supervisor, abort and undefined modes each hold their own r13/r14 copies, all zero after reset.
- R6: Entering or leaving fast-interrupt mode exchanges r8–r12 with a separate copy. All other modes share one copy of r8–r12.
- R7: r0–r7 and r15 never move on a mode change.
- R8: Each of the five banked modes keeps its own saved-status word across mode changes.
- R9: In an unbanked mode, `sts_rdata` reads zero and `sts_we` is ignored. No banked saved-status word is touched.
- R10: A register or saved-status write in the same cycle as a mode change targets the new mode's view.
- R11: `mode_out` takes `mode_in` one cycle after `mode_we`. An unlisted encoding behaves as the unbanked group.
- R12: A request for the current mode, or no request at all, leaves all registers in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode request strobe |
| mode_in | input | 5 | Requested mode |
| rd_addr_a | input | 4 | Read port A index |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 4 | Read port B index |
| rd_data_b | output | 32 | Read port B data |
| reg_we | input | 1 | Register write enable |
| reg_waddr | input | 4 | Register write index |
| reg_wdata | input | 32 | Register write data |
| sts_we | input | 1 | Saved-status write enable |
| sts_wdata | input | 32 | Saved-status write data |
| sts_rdata | output | 32 | Current saved-status word |
| mode_out | output | 5 | Current mode |

## Verification
The bench fills all sixteen registers with distinct values, then walks through changes among the listed modes.

- A user/system switch tells "no bank change" apart from a real swap.
- An interrupt-to-supervisor move shows the shared r8–r12 copy, separate from r13/r14.
- Trips into and out of fast-interrupt mode show the extra r8–r12 exchange.

Writes placed in the same cycle as a mode change show which view a write lands in. Status writes in unbanked mode, and an unlisted encoding, show that nothing leaks into the banks.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW    = 32,
  parameter int NREG  = 16,
  parameter int NBANK = 6,
  parameter int HBASE = 8,
  parameter int NHI   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_we,
  input  logic [4:0]              mode_in,
  input  logic [$clog2(NREG)-1:0] rd_addr_a,
  output logic [DW-1:0]           rd_data_a,
  input  logic [$clog2(NREG)-1:0] rd_addr_b,
  output logic [DW-1:0]           rd_data_b,
  input  logic                    reg_we,
  input  logic [$clog2(NREG)-1:0] reg_waddr,
  input  logic [DW-1:0]           reg_wdata,
  input  logic                    sts_we,
  input  logic [DW-1:0]           sts_wdata,
  output logic [DW-1:0]           sts_rdata,
  output logic [4:0]              mode_out
);
  localparam int BW  = $clog2(NBANK);
  localparam int SPI = NREG - 3;
  localparam int LRI = NREG - 2;
  localparam logic [BW-1:0] FAST = BW'(1);

  function automatic logic [BW-1:0] group_of(input logic [4:0] m);
    case (m)
      5'h11:   return BW'(1);
      5'h12:   return BW'(2);
      5'h13:   return BW'(3);
      5'h17:   return BW'(4);
      5'h1B:   return BW'(5);
      default: return BW'(0);
    endcase
  endfunction

  logic [DW-1:0] gpr [NREG];
  logic [DW-1:0] bsp [NBANK];
  logic [DW-1:0] blr [NBANK];
  logic [DW-1:0] bsts [NBANK];
  logic [DW-1:0] hi [2][NHI];
  logic [DW-1:0] sts;
  logic [4:0]    mode;

  logic [BW-1:0] og, ng;
  logic          swap, fast_x;

  assign og     = group_of(mode);
  assign ng     = mode_we ? group_of(mode_in) : og;
  assign swap   = (og != ng);
  assign fast_x = (og == FAST) || (ng == FAST);

  assign rd_data_a = gpr[rd_addr_a];
  assign rd_data_b = gpr[rd_addr_b];
  assign sts_rdata = (og == '0) ? '0 : sts;
  assign mode_out  = mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) gpr[i] <= '0;
      for (int b = 0; b < NBANK; b++) begin
        bsp[b]  <= '0;
        blr[b]  <= '0;
        bsts[b] <= '0;
      end
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < NHI; k++) hi[s][k] <= '0;
      sts  <= '0;
      mode <= 5'h1F;
    end else begin
      if (mode_we) mode <= mode_in;
      if (swap) begin
        if (fast_x)
          for (int k = 0; k < NHI; k++) begin
            hi[og == FAST][k] <= gpr[HBASE+k];
            gpr[HBASE+k]      <= hi[ng == FAST][k];
          end
        bsp[og]  <= gpr[SPI];
        blr[og]  <= gpr[LRI];
        bsts[og] <= sts;
        gpr[SPI] <= bsp[ng];
        gpr[LRI] <= blr[ng];
        sts      <= bsts[ng];
      end
      if (reg_we) gpr[reg_waddr] <= reg_wdata;
      if (sts_we && ng != '0) sts <= sts_wdata;
    end
  end
endmodule

module banked_regfile_chk #(
  parameter int DW   = 32,
  parameter int NREG = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mode_we,
  input logic [4:0]              mode_in,
  input logic                    reg_we,
  input logic [4:0]              mode_out,
  input logic [DW-1:0]           sts_rdata,
  input logic [DW-1:0]           gpr [NREG]
);
  function automatic logic banked(input logic [4:0] m);
    return (m == 5'h11) || (m == 5'h12) || (m == 5'h13) || (m == 5'h17) || (m == 5'h1B);
  endfunction

  p_mode_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> mode_out == $past(mode_in));

  p_mode_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode_out));

  p_unbanked_sts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !banked(mode_out) |-> sts_rdata == '0);

  p_usersys_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we && !reg_we && !banked(mode_in) && !banked(mode_out)
      |=> $stable(gpr[NREG-3]) && $stable(gpr[NREG-2]) && $stable(gpr[8]));

  p_low_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we && !reg_we |=> $stable(gpr[0]) && $stable(gpr[7]) && $stable(gpr[NREG-1]));

  p_same_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we && !reg_we && mode_in == mode_out |=> $stable(gpr[NREG-3]) && $stable(sts_rdata));
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
  .reg_we(reg_we), .mode_out(mode_out), .sts_rdata(sts_rdata), .gpr(gpr)
);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/100ps
module banked_regfile_bench;
  logic clk = 0, rst_n = 0;
  logic mode_we = 0, reg_we = 0, sts_we = 0;
  logic [4:0] mode_in = 0;
  logic [3:0] ra = 0, rb = 0, wa = 0;
  logic [31:0] wd = 0, sd = 0;
  logic [31:0] rda, rdb, srd;
  logic [4:0] mo;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
    .rd_addr_a(ra), .rd_data_a(rda), .rd_addr_b(rb), .rd_data_b(rdb),
    .reg_we(reg_we), .reg_waddr(wa), .reg_wdata(wd),
    .sts_we(sts_we), .sts_wdata(sd), .sts_rdata(srd), .mode_out(mo)
  );

  // reference model
  int m_mode;
  logic [31:0] m_r [16];
  logic [31:0] m_sp [6], m_lr [6], m_st [6];
  logic [31:0] m_hi_fast [5], m_hi_norm [5];
  logic [31:0] m_sts;

  function automatic int grp(input int m);
    case (m)
      'h11: return 1; 'h12: return 2; 'h13: return 3;
      'h17: return 4; 'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 'h1F; m_sts = 0;
      foreach (m_r[i]) m_r[i] = 0;
      for (int b = 0; b < 6; b++) begin m_sp[b] = 0; m_lr[b] = 0; m_st[b] = 0; end
      for (int k = 0; k < 5; k++) begin m_hi_fast[k] = 0; m_hi_norm[k] = 0; end
    end else begin
      int nm, o, n;
      nm = mode_we ? int'(mode_in) : m_mode;
      o = grp(m_mode); n = grp(nm);
      if (o != n) begin
        if (o == 1 || n == 1)
          for (int k = 0; k < 5; k++) begin
            logic [31:0] t;
            t = m_r[8+k];
            if (o == 1) begin m_r[8+k] = m_hi_norm[k]; m_hi_fast[k] = t; end
            else begin m_r[8+k] = m_hi_fast[k]; m_hi_norm[k] = t; end
          end
        m_sp[o] = m_r[13]; m_lr[o] = m_r[14]; m_st[o] = m_sts;
        m_r[13] = m_sp[n]; m_r[14] = m_lr[n]; m_sts = m_st[n];
      end
      m_mode = nm;
      if (reg_we) m_r[wa] = wd;
      if (sts_we && n != 0) m_sts = sd;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // compare whole visible state against the model
  task automatic sweep(input string req);
    for (int i = 0; i < 8; i++) begin
      ra = 4'(i); rb = 4'(i + 8);
      #0.5;
      chk(req, rda, m_r[i]);
      chk(req, rdb, m_r[i+8]);
    end
    chk(req, {27'd0, mo}, 32'(m_mode));
    chk(req, srd, grp(m_mode) == 0 ? 32'h0 : m_sts);
  endtask

  task automatic cyc(input string req, input logic mw, input logic [4:0] m,
                     input logic w, input logic [3:0] a, input logic [31:0] d,
                     input logic sw, input logic [31:0] s);
    mode_we = mw; mode_in = m; reg_we = w; wa = a; wd = d; sts_we = sw; sd = s;
    @(posedge clk); #1;
    mode_we = 0; reg_we = 0; sts_we = 0;
    sweep(req);
  endtask

  task automatic mode_to(input string req, input logic [4:0] m);
    cyc(req, 1, m, 0, 0, 0, 0, 0);
  endtask

  task automatic peek(input string req, input logic [3:0] a, input logic [31:0] exp);
    ra = a; #0.5; chk(req, rda, exp);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1;
    sweep("R1");
    chk("R1", {27'd0, mo}, 32'h1F);
    for (int i = 0; i < 16; i++) cyc("R2", 0, 0, 1, 4'(i), 32'h100 + i, 0, 0);
    peek("R2", 5, 32'h105);
    mode_to("R3", 5'h10);
    peek("R3", 13, 32'h10D);
    mode_to("R4", 5'h12);
    peek("R4", 13, 32'h0);
    peek("R6", 8, 32'h108);
    cyc("R4", 0, 0, 1, 13, 32'hA13, 1, 32'h5A5A);
    cyc("R4", 0, 0, 1, 14, 32'hA14, 0, 0);
    mode_to("R5", 5'h13);
    peek("R5", 13, 32'h0);
    peek("R6", 8, 32'h108);
    chk("R8", srd, 32'h0);
    cyc("R5", 0, 0, 1, 13, 32'hB13, 1, 32'h3C3C);
    mode_to("R6", 5'h11);
    peek("R6", 8, 32'h0);
    peek("R5", 13, 32'h0);
    peek("R7", 0, 32'h100);
    peek("R7", 15, 32'h10F);
    cyc("R6", 0, 0, 1, 8, 32'hF08, 0, 0);
    cyc("R6", 0, 0, 1, 12, 32'hF0C, 0, 0);
    mode_to("R4", 5'h12);
    peek("R6", 8, 32'h108);
    peek("R4", 13, 32'hA13);
    peek("R4", 14, 32'hA14);
    chk("R8", srd, 32'h5A5A);
    cyc("R12", 1, 5'h12, 1, 1, 32'h201, 0, 0);
    peek("R12", 13, 32'hA13);
    cyc("R10", 1, 5'h1F, 1, 13, 32'hC13, 0, 0);
    peek("R10", 13, 32'hC13);
    chk("R9", srd, 32'h0);
    mode_to("R10", 5'h12);
    peek("R10", 13, 32'hA13);
    mode_to("R10", 5'h1F);
    peek("R10", 13, 32'hC13);
    cyc("R9", 0, 0, 0, 0, 0, 1, 32'h7777);
    chk("R9", srd, 32'h0);
    mode_to("R9", 5'h13);
    chk("R9", srd, 32'h3C3C);
    peek("R5", 13, 32'hB13);
    cyc("R10", 1, 5'h11, 0, 0, 0, 1, 32'h9999);
    chk("R10", srd, 32'h9999);
    mode_to("R8", 5'h13);
    chk("R8", srd, 32'h3C3C);
    mode_to("R6", 5'h11);
    chk("R10", srd, 32'h9999);
    peek("R6", 8, 32'hF08);
    peek("R6", 12, 32'hF0C);
    mode_to("R11", 5'h05);
    chk("R11", {27'd0, mo}, 32'h05);
    peek("R11", 13, 32'hC13);
    peek("R11", 8, 32'h108);
    chk("R11", srd, 32'h0);
    rst_n = 0;
    @(posedge clk); #1;
    rst_n = 1;
    sweep("R1");
    mode_to("R1", 5'h12);
    peek("R1", 13, 32'h0);
    chk("R1", srd, 32'h0);
    finish_run();
  end
endmodule